// File: doc/BRIEF.md
# Integer-N Synthesizer Divider and Phase Comparator Core

This block is the digital part of an integer-N frequency synthesizer. A crystal-rate clock (nominally 4 MHz) is divided down to the comparison reference. A second chain gives a slower square wave that serves as the reference for a secondary (sound) loop. The oscillator signal arrives already divided by a fixed external prescaler of 8. It enters as a one-cycle pulse, synchronous to the crystal clock. These pulses are divided by a programmable 12-bit ratio, so one step of the ratio moves the oscillator by 8 × 31.25 kHz = 250 kHz.

A dual-flop phase/frequency detector compares the reference edge with the divided oscillator edge. It drives two enables for an external charge pump: the upper source pulls the loop node high and the lower source pulls it low. A 3-bit test code and a 2-bit extension code set the pump polarity. The same codes can float both sources, force a single source, or route either divider output onto a source so it can be observed on the bench.

Top module: `pll_synth_core`

## Requirements
- R1: While rst_ni is low, pump_up_o, pump_dn_o, pump_hiz_o, tpg_off_o and snd_ref_o are all 0.
- R2: The reference divider produces one comparison edge every REF_DIV clock cycles, the first one REF_DIV cycles after reset release. With test_i = 3'b110, pump_up_o shows a signal that toggles on each comparison edge, and pump_dn_o is 0.
- R3: snd_ref_o is a square wave with a period of SND_DIV clock cycles: it inverts every SND_DIV/2 cycles and starts low after reset.
- R4: The programmable divider emits one output edge per N prescaled pulses, where N is the value of ratio_i (bit 11 weighs 2048, bit 0 weighs 1). The first pulse after reset emits an edge and loads N. With test_i = 3'b111, pump_dn_o toggles on each divider edge, and pump_up_o is 0.
- R5: A ratio_i value below 17 is treated as 17.
- R6: ratio_i is sampled only when the divider reloads, on the pulse that emits an edge. A change in mid-count does not alter the count in progress.
- R7: The detector sets its reference-lead flag on a comparison edge and its oscillator-lead flag on a divider edge. Once both edges have arrived, it clears both flags in the same cycle. Edges that coincide produce no pulse, and the two flags are never both set.
- R8: With test_i = 3'b000 and ext_i = 2'b00, or with test_i = 3'b001, the polarity is non-inverted. The reference-lead flag drives pump_up_o and the oscillator-lead flag drives pump_dn_o, so an oscillator that runs fast pulls the node low. tpg_off_o is 1 only when test_i = 3'b001.
- R9: With test_i = 3'b100, or with test_i = 3'b000 and ext_i other than 2'b00, the polarity is inverted. The oscillator-lead flag drives pump_up_o and the reference-lead flag drives pump_dn_o.
- R10: test_i = 3'b010 gives pump_up_o = 1 and pump_dn_o = 0. test_i = 3'b011 gives pump_up_o = 0 and pump_dn_o = 1.
- R11: test_i = 3'b101 gives pump_hiz_o = 1 with both enables at 0. In every other mode pump_hiz_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vco_pulse_i | input | 1 | One-cycle pulse per prescaled oscillator period |
| ratio_i | input | 12 | Programmable divide ratio N |
| test_i | input | 3 | Test code for the pump mode |
| ext_i | input | 2 | Extension code (polarity when test_i = 000) |
| pump_up_o | output | 1 | Upper (pull-high) source enable |
| pump_dn_o | output | 1 | Lower (pull-low) source enable |
| pump_hiz_o | output | 1 | Both sources floated |
| tpg_off_o | output | 1 | Test pattern generator disable |
| snd_ref_o | output | 1 | Square-wave reference for the secondary loop |

## Verification
The bench builds the block with REF_DIV = 32 and SND_DIV = 64, and keeps the 12-bit ratio and the floor of 17. A ratio near 32 with a pulse on every cycle then matches the comparison rate, so phase lead, lag and drift in both directions occur within a few hundred cycles. Every test code, the clamp of small ratios and ratio changes in mid-count can all be reached in a few thousand cycles.

// File: rtl/pll_synth_pkg.sv
package pll_synth_pkg;
  typedef enum logic [2:0] {
    TM_NORMAL   = 3'b000,
    TM_NOTPG    = 3'b001,
    TM_FORCE_HI = 3'b010,
    TM_FORCE_LO = 3'b011,
    TM_INVERT   = 3'b100,
    TM_HIZ      = 3'b101,
    TM_OBS_REF  = 3'b110,
    TM_OBS_DIV  = 3'b111
  } test_mode_e;

  typedef struct packed {
    logic up;
    logic dn;
    logic hiz;
    logic tpg_off;
  } pump_ctl_t;
endpackage

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int REF_DIV = 128,
  parameter int SND_DIV = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ref_tick_o,
  output logic ref_tgl_o,
  output logic snd_ref_o
);
  localparam int REF_W    = $clog2(REF_DIV);
  localparam int SND_HALF = SND_DIV / 2;
  localparam int SND_W    = $clog2(SND_HALF + 1);

  logic [REF_W-1:0] ref_cnt_q;
  logic [SND_W-1:0] snd_cnt_q;
  logic             snd_wrap;

  assign ref_tick_o = (ref_cnt_q == REF_W'(REF_DIV - 1));
  assign snd_wrap   = (snd_cnt_q == SND_W'(SND_HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_cnt_q <= '0;
      ref_tgl_o <= 1'b0;
    end else if (ref_tick_o) begin
      ref_cnt_q <= '0;
      ref_tgl_o <= ~ref_tgl_o;
    end else begin
      ref_cnt_q <= ref_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snd_cnt_q <= '0;
      snd_ref_o <= 1'b0;
    end else if (snd_wrap) begin
      snd_cnt_q <= '0;
      snd_ref_o <= ~snd_ref_o;
    end else begin
      snd_cnt_q <= snd_cnt_q + 1'b1;
    end
  end

  assert_single_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_tick_o |=> !ref_tick_o);
  assert_snd_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snd_wrap |=> $stable(snd_ref_o));
endmodule

// File: rtl/prog_divider.sv
module prog_divider #(
  parameter int N_W   = 12,
  parameter int N_MIN = 17
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           vco_pulse_i,
  input  logic [N_W-1:0] ratio_i,
  output logic           div_tick_o,
  output logic           div_tgl_o
);
  logic [N_W-1:0] cnt_q;
  logic [N_W-1:0] n_eff;

  assign n_eff      = (ratio_i < N_W'(N_MIN)) ? N_W'(N_MIN) : ratio_i;
  assign div_tick_o = vco_pulse_i && (cnt_q <= N_W'(1));

  // reload samples the ratio only on terminal count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      div_tgl_o <= 1'b0;
    end else if (div_tick_o) begin
      cnt_q     <= n_eff;
      div_tgl_o <= ~div_tgl_o;
    end else if (vco_pulse_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_reload_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_tick_o |=> (cnt_q >= N_W'(N_MIN)));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vco_pulse_i |=> $stable(cnt_q));
endmodule

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_edge_i,
  input  logic div_edge_i,
  output logic ref_lead_o,
  output logic div_lead_o
);
  logic up_set, dn_set;

  assign up_set = ref_lead_o | ref_edge_i;
  assign dn_set = div_lead_o | div_edge_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_lead_o <= 1'b0;
      div_lead_o <= 1'b0;
    end else if (up_set && dn_set) begin
      ref_lead_o <= 1'b0;
      div_lead_o <= 1'b0;
    end else begin
      ref_lead_o <= up_set;
      div_lead_o <= dn_set;
    end
  end

  assert_pfd_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ref_lead_o && div_lead_o));
  assert_pfd_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_lead_o && div_edge_i) |=> !ref_lead_o && !div_lead_o);
endmodule

// File: rtl/pump_mux.sv
module pump_mux
  import pll_synth_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] test_i,
  input  logic [1:0] ext_i,
  input  logic       ref_lead_i,
  input  logic       div_lead_i,
  input  logic       ref_tgl_i,
  input  logic       div_tgl_i,
  output pump_ctl_t  ctl_o
);
  test_mode_e mode;
  logic       invert;

  assign mode   = test_mode_e'(test_i);
  assign invert = (mode == TM_INVERT) || ((mode == TM_NORMAL) && (ext_i != 2'b00));

  always_comb begin
    ctl_o = '0;
    unique case (mode)
      TM_NORMAL, TM_NOTPG, TM_INVERT: begin
        ctl_o.up = invert ? div_lead_i : ref_lead_i;
        ctl_o.dn = invert ? ref_lead_i : div_lead_i;
        ctl_o.tpg_off = (mode == TM_NOTPG);
      end
      TM_FORCE_HI: ctl_o.up  = 1'b1;
      TM_FORCE_LO: ctl_o.dn  = 1'b1;
      TM_HIZ:      ctl_o.hiz = 1'b1;
      TM_OBS_REF:  ctl_o.up  = ref_tgl_i;
      TM_OBS_DIV:  ctl_o.dn  = div_tgl_i;
      default:     ctl_o     = '0;
    endcase
  end

  assert_hiz_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o.hiz |-> !ctl_o.up && !ctl_o.dn);
  assert_one_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctl_o.up, ctl_o.dn}));
endmodule

// File: rtl/pll_synth_core.sv
module pll_synth_core
  import pll_synth_pkg::*;
#(
  parameter int REF_DIV = 128,
  parameter int SND_DIV = 512,
  parameter int N_W     = 12,
  parameter int N_MIN   = 17
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           vco_pulse_i,
  input  logic [N_W-1:0] ratio_i,
  input  logic [2:0]     test_i,
  input  logic [1:0]     ext_i,
  output logic           pump_up_o,
  output logic           pump_dn_o,
  output logic           pump_hiz_o,
  output logic           tpg_off_o,
  output logic           snd_ref_o
);
  logic      ref_tick, ref_tgl, div_tick, div_tgl;
  logic      ref_lead, div_lead;
  pump_ctl_t ctl;

  ref_divider #(.REF_DIV(REF_DIV), .SND_DIV(SND_DIV)) u_ref (
    .clk_i, .rst_ni, .ref_tick_o(ref_tick), .ref_tgl_o(ref_tgl), .snd_ref_o(snd_ref_o));

  prog_divider #(.N_W(N_W), .N_MIN(N_MIN)) u_div (
    .clk_i, .rst_ni, .vco_pulse_i, .ratio_i, .div_tick_o(div_tick), .div_tgl_o(div_tgl));

  pfd_core u_pfd (
    .clk_i, .rst_ni, .ref_edge_i(ref_tick), .div_edge_i(div_tick),
    .ref_lead_o(ref_lead), .div_lead_o(div_lead));

  pump_mux u_mux (
    .clk_i, .rst_ni, .test_i, .ext_i, .ref_lead_i(ref_lead), .div_lead_i(div_lead),
    .ref_tgl_i(ref_tgl), .div_tgl_i(div_tgl), .ctl_o(ctl));

  assign pump_up_o  = ctl.up;
  assign pump_dn_o  = ctl.dn;
  assign pump_hiz_o = ctl.hiz;
  assign tpg_off_o  = ctl.tpg_off;
endmodule

// File: tb/sim_pll_synth_core.sv
module sim_pll_synth_core;
  localparam int R = 32;
  localparam int S = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vco = 1'b0;
  logic [11:0] ratio = 12'd40;
  logic [2:0]  tb = 3'b000;
  logic [1:0]  xb = 2'b00;
  logic        up, dn, hiz, tpg, snd;

  int checks = 0, errors = 0, cyc = 0, gap = 1, gcnt = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  pll_synth_core #(.REF_DIV(R), .SND_DIV(S)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .vco_pulse_i(vco), .ratio_i(ratio), .test_i(tb),
    .ext_i(xb), .pump_up_o(up), .pump_dn_o(dn), .pump_hiz_o(hiz), .tpg_off_o(tpg),
    .snd_ref_o(snd));

  // behavioural reference model
  int m_ref, m_snd, m_dcnt;
  bit m_sndo, m_rtgl, m_dtgl, m_up, m_dn;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ref = 0; m_snd = 0; m_dcnt = 0;
      m_sndo = 0; m_rtgl = 0; m_dtgl = 0; m_up = 0; m_dn = 0;
    end else begin
      bit rt, dt, nu, nd;
      rt = (m_ref == R - 1);
      dt = vco && (m_dcnt <= 1);
      m_ref = rt ? 0 : m_ref + 1;
      if (rt) m_rtgl = !m_rtgl;
      if (m_snd == S / 2 - 1) begin m_snd = 0; m_sndo = !m_sndo; end
      else m_snd = m_snd + 1;
      if (vco) begin
        if (m_dcnt <= 1) begin
          m_dcnt = (ratio < 17) ? 17 : int'(ratio);
          m_dtgl = !m_dtgl;
        end else m_dcnt = m_dcnt - 1;
      end
      nu = m_up || rt;
      nd = m_dn || dt;
      if (nu && nd) begin m_up = 0; m_dn = 0; end
      else begin m_up = nu; m_dn = nd; end
    end
  end

  function automatic logic [3:0] expect_ctl();
    logic [3:0] e;
    bit inv;
    e = 4'b0000;
    inv = (tb == 3'b100) || (tb == 3'b000 && xb != 2'b00);
    case (tb)
      3'b000, 3'b001, 3'b100: begin
        e[3] = inv ? m_dn : m_up;
        e[2] = inv ? m_up : m_dn;
        e[0] = (tb == 3'b001);
      end
      3'b010: e[3] = 1'b1;
      3'b011: e[2] = 1'b1;
      3'b101: e[1] = 1'b1;
      3'b110: e[3] = m_rtgl;
      default: e[2] = m_dtgl;
    endcase
    return e;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] e;
      e = expect_ctl();
      checks++;
      if ({up, dn, hiz, tpg} !== e) begin
        errors++;
        $display("FAIL %s cyc %0d tb=%b x=%b pump act=%b exp=%b", cur_req, cyc, tb, xb,
                 {up, dn, hiz, tpg}, e);
      end
      checks++;
      if (snd !== m_sndo) begin
        errors++;
        $display("FAIL R3 cyc %0d snd act=%b exp=%b", cyc, snd, m_sndo);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // prescaled pulse generator, one pulse every gap cycles
  always @(negedge clk) begin
    #1;
    gcnt = (gcnt + 1 >= gap) ? 0 : gcnt + 1;
    vco = rst_n && (gcnt == 0);
  end

  task automatic phase(input logic [2:0] t, input logic [1:0] x, input int n,
                       input int g, input string req, input int cycles);
    @(negedge clk); #1;
    tb = t; xb = x; ratio = 12'(n); gap = g; cur_req = req;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({up, dn, hiz, tpg, snd} !== 5'b0) begin
      errors++;
      $display("FAIL R1 reset outputs act=%b exp=00000", {up, dn, hiz, tpg, snd});
    end
    @(negedge clk); #1;
    rst_n = 1'b1;
    phase(3'b110, 2'b00, 40, 1, "R2", 400);
    phase(3'b111, 2'b00, 20, 2, "R4", 400);
    phase(3'b111, 2'b00, 5, 1, "R5", 300);
    phase(3'b111, 2'b00, 0, 1, "R5", 100);
    phase(3'b111, 2'b00, 17, 1, "R6", 25);
    phase(3'b111, 2'b00, 60, 1, "R6", 300);
    phase(3'b000, 2'b00, 32, 1, "R8", 600);
    phase(3'b000, 2'b00, 30, 1, "R8", 600);
    phase(3'b000, 2'b00, 34, 1, "R7", 600);
    phase(3'b001, 2'b00, 31, 1, "R8", 400);
    phase(3'b100, 2'b00, 30, 1, "R9", 400);
    phase(3'b100, 2'b00, 35, 1, "R9", 400);
    phase(3'b000, 2'b01, 33, 1, "R9", 300);
    phase(3'b000, 2'b10, 29, 1, "R9", 300);
    phase(3'b000, 2'b11, 17, 2, "R9", 300);
    phase(3'b010, 2'b00, 32, 1, "R10", 100);
    phase(3'b011, 2'b11, 32, 1, "R10", 100);
    phase(3'b101, 2'b00, 32, 1, "R11", 100);
    phase(3'b110, 2'b01, 4095, 3, "R2", 200);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule